// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block takes an 8-bit unsigned binary value and turns it into three decimal digits: a 2-bit hundreds digit and 4-bit tens and units digits. It runs the double-dabble method one step per clock. One working register holds the decimal columns above the binary operand. On every iteration, each decimal column that holds 5 or more first has 3 added to it, on its own and apart from the other columns. The whole register then moves one bit to the left. When the last operand bit has entered the decimal columns, the columns hold the answer.

A client pulses `start_i` with the operand while the block is idle. The block raises `busy_o` and runs eight iterations, one per clock. On the last iteration it drops `busy_o`, pulses `done_o` for one cycle and updates the digit outputs. The digit outputs are registered and keep the last result through later conversions until the next result is ready. A start that arrives while a conversion is running has no effect.

Top module: `bcd_seq_conv`

## Requirements
- R1: While reset is asserted and in the cycle after it, `busy_o`, `done_o`, `hund_o`, `tens_o` and `units_o` are all zero. Reset is synchronous and active high.
- R2: A `start_i` pulse sampled while `busy_o` is low captures `operand_i`, and `busy_o` is high from the next cycle on.
- R3: `done_o` rises exactly 8 clock edges after the edge that sampled the accepted start. `busy_o` falls on that same edge, and `done_o` stays high for exactly one cycle.
- R4: When `done_o` is high, `hund_o`, `tens_o` and `units_o` equal value/100, (value/10)%10 and value%10 of the captured operand. This holds for all 256 values. For example, 0xFF gives 2,5,5 and 0x0E gives 0,1,4.
- R5: On each iteration, every 4-bit decimal column that holds 5 to 9 gets 3 added to it, and a column that holds 0 to 4 is left as it is. Each column is corrected on its own before the shift, so the tens and units outputs never exceed 9.
- R6: The digit outputs change only on the edge that raises `done_o`. They hold their value at all other times, including while a later conversion runs.
- R7: A `start_i` pulse sampled while `busy_o` is high is ignored. It neither restarts nor lengthens the conversion, and it does not change the result.
- R8: A start sampled in the cycle where `done_o` is high is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled when idle |
| operand_i | input | 8 | Binary value to convert |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-ready pulse |
| hund_o | output | 2 | Hundreds digit |
| tens_o | output | 4 | Tens digit |
| units_o | output | 4 | Units digit |

## Verification
The assertions assume that reset is held for at least one clock at the start of the run. They also assume that `start_i` and `operand_i` only change away from the rising edge. The bench meets both: it holds reset for four cycles and drives every input on the falling clock edge. The properties make no assumption about how often the client raises `start_i`. The bench exercises that freedom on purpose, with a start inserted in the middle of a conversion and starts issued in the very cycle that `done_o` is high.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    // A column value at or above this threshold is corrected before the shift
    localparam int unsigned FIX_MIN = 5;
    // Amount added to a corrected column
    localparam int unsigned FIX_ADD = 3;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/bcd_col_fix.sv
module bcd_col_fix
    import bcd_conv_pkg::*;
#(
    parameter int unsigned DIG_W = 4
) (
    input  logic [DIG_W-1:0] digit_i,
    output logic [DIG_W-1:0] digit_o
);

    always_comb begin
        if (digit_i >= DIG_W'(FIX_MIN)) begin
            digit_o = digit_i + DIG_W'(FIX_ADD);
        end else begin
            digit_o = digit_i;
        end
    end

endmodule

// File: rtl/bcd_shift_stage.sv
module bcd_shift_stage #(
    parameter int unsigned BIN_W   = 8,
    parameter int unsigned DIG_W   = 4,
    parameter int unsigned NUM_DIG = 3,
    localparam int unsigned SR_W   = NUM_DIG * DIG_W + BIN_W
) (
    input  logic [SR_W-1:0] sr_i,
    output logic [SR_W-1:0] sr_o
);

    logic [SR_W-1:0] fixed;

    // The binary part passes through without correction
    assign fixed[BIN_W-1:0] = sr_i[BIN_W-1:0];

    // One correction cell per decimal column
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_col
        bcd_col_fix #(
            .DIG_W (DIG_W)
        ) u_fix (
            .digit_i (sr_i [BIN_W + g*DIG_W +: DIG_W]),
            .digit_o (fixed[BIN_W + g*DIG_W +: DIG_W])
        );
    end

    // Move the whole register one place to the left
    assign sr_o = {fixed[SR_W-2:0], 1'b0};

endmodule

// File: rtl/bcd_seq_conv.sv
module bcd_seq_conv
    import bcd_conv_pkg::*;
#(
    parameter int unsigned BIN_W  = 8,
    parameter int unsigned DIG_W  = 4,
    parameter int unsigned HUND_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [BIN_W-1:0]  operand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [HUND_W-1:0] hund_o,
    output logic [DIG_W-1:0]  tens_o,
    output logic [DIG_W-1:0]  units_o
);

    localparam int unsigned NUM_DIG = 3;
    localparam int unsigned SR_W    = NUM_DIG * DIG_W + BIN_W;
    localparam int unsigned CNT_W   = (BIN_W > 1) ? $clog2(BIN_W) : 1;
    localparam int unsigned UNI_LSB = BIN_W;
    localparam int unsigned TEN_LSB = BIN_W + DIG_W;
    localparam int unsigned HUN_LSB = BIN_W + 2 * DIG_W;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [SR_W-1:0]    sr;
        logic               done;
        logic [HUND_W-1:0]  hund;
        logic [DIG_W-1:0]   tens;
        logic [DIG_W-1:0]   units;
    } state_t;

    state_t          s_d;
    state_t          s_q;
    logic [SR_W-1:0] sr_step;

    bcd_shift_stage #(
        .BIN_W   (BIN_W),
        .DIG_W   (DIG_W),
        .NUM_DIG (NUM_DIG)
    ) u_stage (
        .sr_i (s_q.sr),
        .sr_o (sr_step)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.sr    = {{(SR_W-BIN_W){1'b0}}, operand_i};
                    s_d.cnt   = '0;
                    s_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                s_d.sr  = sr_step;
                s_d.cnt = s_q.cnt + CNT_W'(1);
                if (s_q.cnt == CNT_W'(BIN_W - 1)) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                    s_d.hund  = sr_step[HUN_LSB +: HUND_W];
                    s_d.tens  = sr_step[TEN_LSB +: DIG_W];
                    s_d.units = sr_step[UNI_LSB +: DIG_W];
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.phase == PH_RUN);
    assign done_o  = s_q.done;
    assign hund_o  = s_q.hund;
    assign tens_o  = s_q.tens;
    assign units_o = s_q.units;

endmodule

// File: rtl/bcd_seq_conv_chk.sv
module bcd_seq_conv_chk #(
    parameter int unsigned BIN_W  = 8,
    parameter int unsigned DIG_W  = 4,
    parameter int unsigned HUND_W = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              start_i,
    input logic              busy_i,
    input logic              done_i,
    input logic [HUND_W-1:0] hund_i,
    input logic [DIG_W-1:0]  tens_i,
    input logic [DIG_W-1:0]  units_i
);

    localparam int unsigned CW = $clog2(BIN_W + 2);

    // Counts the edges at which busy was seen high
    logic [CW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (busy_i) begin
            run_q <= run_q + CW'(1);
        end else begin
            run_q <= '0;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_i) |=> busy_i); // R2

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> !done_i); // R3

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |-> (!busy_i && $past(busy_i))); // R3

    AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_i) |-> (run_q == CW'(BIN_W))); // R7

    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_i |-> $stable({hund_i, tens_i, units_i})); // R6

    AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (tens_i <= DIG_W'(9)) && (units_i <= DIG_W'(9))); // R5

endmodule

bind bcd_seq_conv bcd_seq_conv_chk #(
    .BIN_W  (BIN_W),
    .DIG_W  (DIG_W),
    .HUND_W (HUND_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .busy_i  (busy_o),
    .done_i  (done_o),
    .hund_i  (hund_o),
    .tens_i  (tens_o),
    .units_i (units_o)
);

// File: tb/bcd_seq_conv_tb.sv
module bcd_seq_conv_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] op = 8'h00;
    logic       busy;
    logic       done;
    logic [1:0] hund;
    logic [3:0] tens;
    logic [3:0] units;

    typedef struct packed {
        logic [1:0] h;
        logic [3:0] t;
        logic [3:0] u;
    } exp_t;

    exp_t q[$];
    exp_t last_exp = '0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic prev_done = 1'b0;

    always #4 clk = ~clk;

    bcd_seq_conv u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .start_i   (start),
        .operand_i (op),
        .busy_o    (busy),
        .done_o    (done),
        .hund_o    (hund),
        .tens_o    (tens),
        .units_o   (units)
    );

    function automatic exp_t model(int v);
        return exp_t'{2'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: pops the expected result whenever a result is flagged
    always @(negedge clk) begin
        exp_t e;
        if (!rst && done) begin
            chk(!prev_done, "R3", "done longer than one cycle", 2, 1);
            if (q.size() == 0) begin
                chk(1'b0, "R3", "done with nothing pending", 1, 0);
            end else begin
                e = q.pop_front();
                chk(hund  == e.h, "R4", "hundreds", int'(hund),  int'(e.h));
                chk(tens  == e.t, "R4", "tens",     int'(tens),  int'(e.t));
                chk(units == e.u, "R4", "units",    int'(units), int'(e.u));
            end
        end
        prev_done = done;
    end

    // Driver: called just after a falling edge; returns at the falling edge where done is high
    task automatic run(int v, bit intrude);
        int lat;
        start = 1'b1;
        op    = 8'(v);
        q.push_back(model(v));
        @(negedge clk);
        start = 1'b0;
        op    = 8'hA5;
        lat   = 1;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        while (!done && lat < 40) begin
            if (intrude && lat == 3) begin
                start = 1'b1;
                op    = ~8'(v);
            end
            if (lat == 5) begin
                chk({hund, tens, units} == last_exp, "R6", "outputs during run",
                    int'({hund, tens, units}), int'(last_exp));
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(lat == 9, "R3", "start-to-done latency", lat, 9);
        chk(busy == 1'b0, "R3", "busy at done", int'(busy), 0);
        last_exp = model(v);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0,  "R1", "busy in reset",  int'(busy),  0);
        chk(done == 1'b0,  "R1", "done in reset",  int'(done),  0);
        chk(hund == 2'd0,  "R1", "hund in reset",  int'(hund),  0);
        chk(tens == 4'd0,  "R1", "tens in reset",  int'(tens),  0);
        chk(units == 4'd0, "R1", "units in reset", int'(units), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, hund, tens, units} == '0, "R1", "state after reset",
            int'({busy, done, hund, tens, units}), 0);

        // R4/R5: directed corner values, several columns needing correction
        run(8'hFF, 1'b0);
        run(8'h0E, 1'b0);

        // R6: outputs hold while idle
        repeat (6) begin
            @(negedge clk);
            chk({hund, tens, units} == last_exp, "R6", "outputs while idle",
                int'({hund, tens, units}), int'(last_exp));
            chk(!busy && !done, "R6", "idle flags", int'({busy, done}), 0);
        end

        // R7: start while busy is ignored
        run(137, 1'b1);
        @(negedge clk);
        chk(busy == 1'b0, "R7", "no restart after ignored start", int'(busy), 0);

        // R8 and R4: back-to-back sweep, each start issued in the done cycle
        for (int v = 0; v < 256; v++) begin
            run(v, 1'b0);
        end

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4", "results outstanding", q.size(), 0);
        summary();
        $finish;
    end

endmodule